// File: doc/BRIEF.md
# USB Device Endpoint Control and Handshake Decision

This block holds the control settings of one USB device endpoint and decides, token by token, how the endpoint answers. The receive (OUT) and transmit (IN) directions are configured separately. Each has a transfer kind, an enable bit and a stall bit. Each also has a self-clearing data-toggle reset. The receive side also has a test-only toggle-inhibit bit. The block keeps the expected DATA0/DATA1 value for each direction. The packet engine presents a token with its direction and, for OUT data, the received data PID. One cycle later the block returns a response code together with the PID that applies.

On a control endpoint, a SETUP packet clears the stall bit on its own. Hardware keeps the bit cleared while the setup-status flag stays raised. Software writes and readback use a single 16-bit control word.

Top module: `usb_ep_ctrl`

## Requirements
- R1: After reset the control word reads 0x0000 (control kind, disabled, not stalled, inhibit off), both toggles are 0 and no response is issued.
- R2: Control word layout: receive fields at bits 1:0 kind (0 control, 1 isochronous, 2 bulk, 3 interrupt), bit 2 enable, bit 3 stall, bit 4 toggle reset, bit 5 toggle inhibit. Transmit fields at bits 9:8 kind, bit 10 enable, bit 11 stall, bit 12 toggle reset. Writes take effect on the next cycle, and reads return the stored fields.
- R3: A token to a disabled direction gets response code 3 (silent, no data accepted or sent), and its toggle does not change.
- R4: A token to an enabled, non-isochronous, stalled direction gets code 1 (STALL) on every token until the stall bit is cleared. The toggle does not change.
- R5: On a control-kind direction, a setup-received pulse clears the stall bit. While the setup-status flag is high, the bit stays cleared and writes of 1 are ignored. A stall write in the same cycle as the setup pulse loses.
- R6: A setup-received pulse does not clear the stall bit of a non-control direction.
- R7: An OUT token whose PID (0 = DATA0, 1 = DATA1) equals the expected receive toggle gets code 0 (accept), and the toggle flips. A mismatched PID gets code 2 (acknowledge and discard), and the toggle stays.
- R8: An IN token on an enabled, unstalled, non-isochronous direction gets code 0, with the PID output equal to the transmit toggle, and the toggle then flips.
- R9: Writing 1 to a toggle-reset bit sets that direction's expected PID to DATA0, and the bit always reads back 0. Writing 0 to it has no effect.
- R10: With receive toggle inhibit set, every OUT data PID is accepted (code 0) and the receive toggle does not change.
- R11: An isochronous direction accepts every token with code 0, even when stalled, and its toggle never changes.
- R12: A response (hs_valid with code and PID) appears exactly one cycle after each token and never without one. The PID output is the expected toggle of the token's direction at the time of the token.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 16 | Control word write data |
| cfg_rdata | output | 16 | Control word readback |
| setup_rcvd | input | 1 | One-cycle pulse: SETUP packet received |
| setup_stat | input | 1 | Setup-status flag still pending |
| tok_valid | input | 1 | Token event strobe |
| tok_dir | input | 1 | Token direction: 0 OUT (receive), 1 IN (transmit) |
| tok_pid | input | 1 | Received data PID for OUT: 0 DATA0, 1 DATA1 |
| hs_valid | output | 1 | Response valid, one cycle after a token |
| hs_code | output | 2 | 0 accept/send, 1 STALL, 2 discard, 3 silent |
| hs_pid | output | 1 | Expected/sent data PID of the token's direction |
| rx_tgl | output | 1 | Expected receive data PID |
| tx_tgl | output | 1 | Next transmit data PID |

## Verification
The assertions watch the cycle-local rules on every edge. A setup pulse on a control direction must leave stall cleared. A raised setup-status flag must hold it cleared. A toggle reset must leave DATA0, and an advance must flip the toggle. Every response must follow a token. A disabled direction must stay silent, and an isochronous direction must never stall. The scoreboard scenarios show the properties that depend on a sequence of events. These include toggle ordering across several packets and a mismatch leaving the toggle in place. They also include stall persisting across tokens, the priority of the setup clear over a same-cycle write, bulk stall surviving a SETUP, and the toggle-reset bit reading back as zero.

// File: rtl/usb_ep_pkg.sv
// Shared types and control-word field positions for the endpoint control block.
// Assumes two directions: index 0 receive (OUT), index 1 transmit (IN).
package usb_ep_pkg;

    localparam int N_DIR     = 2;
    localparam int KIND_LSB  = 0;
    localparam int EN_OFS    = 2;
    localparam int STALL_OFS = 3;
    localparam int TRST_OFS  = 4;
    localparam int INH_OFS   = 5;

    typedef enum logic [1:0] {
        EP_CTRL = 2'd0,
        EP_ISO  = 2'd1,
        EP_BULK = 2'd2,
        EP_INTR = 2'd3
    } ep_kind_e;

    typedef enum logic [1:0] {
        RSP_ACCEPT = 2'd0,
        RSP_STALL  = 2'd1,
        RSP_DROP   = 2'd2,
        RSP_SILENT = 2'd3
    } ep_rsp_e;

    typedef struct packed {
        ep_kind_e kind;
        logic     en;
        logic     stall;
        logic     inh;
    } dir_cfg_t;

endpackage

// File: rtl/usb_ep_cfg_reg.sv
// Control word storage for both directions.
// Applies software writes and the SETUP-driven stall clear.
// Emits one-cycle toggle-reset pulses.
// Assumes setup_rcvd is a single-cycle pulse. Toggle inhibit exists only for receive.
module usb_ep_cfg_reg
    import usb_ep_pkg::*;
#(
    parameter int REG_W      = 16,
    parameter int DIR_STRIDE = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_we,
    input  logic [REG_W-1:0]        cfg_wdata,
    input  logic                    setup_rcvd,
    input  logic                    setup_stat,
    output dir_cfg_t [N_DIR-1:0]    cfg_o,
    output logic     [N_DIR-1:0]    trst_o,
    output logic     [REG_W-1:0]    cfg_rdata
);

    dir_cfg_t [N_DIR-1:0] cfg_q;
    logic     [N_DIR-1:0] stall_force;
    logic                 unused_wdata;

    assign unused_wdata = ^cfg_wdata;

    // Decide per direction whether hardware must hold stall cleared, and form toggle-reset pulses.
    always_comb begin
        for (int d = 0; d < N_DIR; d++) begin
            stall_force[d] = (cfg_q[d].kind == EP_CTRL) && (setup_rcvd || setup_stat);
            trst_o[d]      = cfg_we && cfg_wdata[d*DIR_STRIDE + TRST_OFS];
        end
    end

    // Register update: the setup clear outranks a software stall write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            for (int d = 0; d < N_DIR; d++) begin
                if (cfg_we) begin
                    cfg_q[d].kind <= ep_kind_e'(cfg_wdata[d*DIR_STRIDE + KIND_LSB +: 2]);
                    cfg_q[d].en   <= cfg_wdata[d*DIR_STRIDE + EN_OFS];
                    cfg_q[d].inh  <= (d == 0) ? cfg_wdata[d*DIR_STRIDE + INH_OFS] : 1'b0;
                end
                if (stall_force[d])
                    cfg_q[d].stall <= 1'b0;
                else if (cfg_we)
                    cfg_q[d].stall <= cfg_wdata[d*DIR_STRIDE + STALL_OFS];
            end
        end
    end

    // Readback: stored fields only, so toggle-reset positions read zero.
    always_comb begin
        cfg_rdata = '0;
        for (int d = 0; d < N_DIR; d++) begin
            cfg_rdata[d*DIR_STRIDE + KIND_LSB +: 2]  = cfg_q[d].kind;
            cfg_rdata[d*DIR_STRIDE + EN_OFS]         = cfg_q[d].en;
            cfg_rdata[d*DIR_STRIDE + STALL_OFS]      = cfg_q[d].stall;
            cfg_rdata[d*DIR_STRIDE + INH_OFS]        = cfg_q[d].inh;
        end
    end

    assign cfg_o = cfg_q;

    for (genvar g = 0; g < N_DIR; g++) begin : g_chk
        // R5
        setup_clears_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (setup_rcvd && cfg_q[g].kind == EP_CTRL) |=> !cfg_q[g].stall);
        // R5
        setup_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (setup_stat && cfg_q[g].kind == EP_CTRL) |=> !cfg_q[g].stall);
        // R6
        bulk_stall_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!cfg_we && cfg_q[g].kind != EP_CTRL && cfg_q[g].stall) |=> cfg_q[g].stall);
    end

endmodule

// File: rtl/usb_ep_toggle.sv
// Expected DATA0/DATA1 tracker for one direction.
// Assumes clr and adv are single-cycle strobes. When both arrive together, clr wins.
module usb_ep_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic adv,
    output logic tgl
);

    // Toggle state: reset to DATA0 on clear, flip on an advance.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tgl <= 1'b0;
        else if (clr)
            tgl <= 1'b0;
        else if (adv)
            tgl <= ~tgl;
    end

    // R9
    tgl_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !tgl);
    // R7
    tgl_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !clr) |=> (tgl != $past(tgl)));

endmodule

// File: rtl/usb_ep_resp.sv
// Per-token response decision.
// Priority order: disabled, isochronous, stall, then toggle check.
// Produces a registered response and a combinational toggle-advance request.
// Assumes tok_pid is meaningful only for OUT tokens.
module usb_ep_resp
    import usb_ep_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tok_valid,
    input  logic                 tok_dir,
    input  logic                 tok_pid,
    input  dir_cfg_t [N_DIR-1:0] cfg_i,
    input  logic     [N_DIR-1:0] tgl_i,
    output logic     [N_DIR-1:0] adv_o,
    output logic                 hs_valid,
    output ep_rsp_e              hs_code,
    output logic                 hs_pid
);

    dir_cfg_t sel;
    logic     exp_pid;
    ep_rsp_e  rsp;
    logic     adv_d;

    // Select the token direction's settings and rank the possible answers.
    always_comb begin
        sel     = cfg_i[tok_dir];
        exp_pid = tgl_i[tok_dir];
        adv_d   = 1'b0;
        if (!sel.en) begin
            rsp = RSP_SILENT;
        end else if (sel.kind == EP_ISO) begin
            rsp = RSP_ACCEPT;
        end else if (sel.stall) begin
            rsp = RSP_STALL;
        end else if (tok_dir) begin
            rsp   = RSP_ACCEPT;
            adv_d = 1'b1;
        end else if (sel.inh) begin
            rsp = RSP_ACCEPT;
        end else if (tok_pid == exp_pid) begin
            rsp   = RSP_ACCEPT;
            adv_d = 1'b1;
        end else begin
            rsp = RSP_DROP;
        end
    end

    // Route the advance request to the token's direction only.
    always_comb begin
        adv_o = '0;
        if (tok_valid && adv_d)
            adv_o[tok_dir] = 1'b1;
    end

    // Register the response one cycle after the token.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_valid <= 1'b0;
            hs_code  <= RSP_ACCEPT;
            hs_pid   <= 1'b0;
        end else begin
            hs_valid <= tok_valid;
            hs_code  <= rsp;
            hs_pid   <= exp_pid;
        end
    end

    // R12
    resp_follows_tok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hs_valid |-> $past(tok_valid));
    // R3
    disabled_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_valid && !cfg_i[tok_dir].en) |=> (hs_code == RSP_SILENT));
    // R11
    iso_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_valid && cfg_i[tok_dir].en && cfg_i[tok_dir].kind == EP_ISO) |=> (hs_code == RSP_ACCEPT));
    // R4
    stall_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_valid && cfg_i[tok_dir].en && cfg_i[tok_dir].kind != EP_ISO && cfg_i[tok_dir].stall)
        |=> (hs_code == RSP_STALL));

endmodule

// File: rtl/usb_ep_ctrl.sv
// Top level: one USB device endpoint's control word, DATA0/DATA1 trackers and response logic.
// Assumes a single clock domain with tokens presented as one-cycle strobes.
module usb_ep_ctrl
    import usb_ep_pkg::*;
#(
    parameter int REG_W      = 16,
    parameter int DIR_STRIDE = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [REG_W-1:0] cfg_wdata,
    output logic [REG_W-1:0] cfg_rdata,
    input  logic             setup_rcvd,
    input  logic             setup_stat,
    input  logic             tok_valid,
    input  logic             tok_dir,
    input  logic             tok_pid,
    output logic             hs_valid,
    output logic [1:0]       hs_code,
    output logic             hs_pid,
    output logic             rx_tgl,
    output logic             tx_tgl
);

    dir_cfg_t [N_DIR-1:0] cfg;
    logic     [N_DIR-1:0] trst;
    logic     [N_DIR-1:0] adv;
    logic     [N_DIR-1:0] tgl;
    ep_rsp_e              code;

    usb_ep_cfg_reg #(.REG_W(REG_W), .DIR_STRIDE(DIR_STRIDE)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_wdata  (cfg_wdata),
        .setup_rcvd (setup_rcvd),
        .setup_stat (setup_stat),
        .cfg_o      (cfg),
        .trst_o     (trst),
        .cfg_rdata  (cfg_rdata)
    );

    for (genvar d = 0; d < N_DIR; d++) begin : g_tgl
        usb_ep_toggle u_tgl (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (trst[d]),
            .adv   (adv[d]),
            .tgl   (tgl[d])
        );
    end

    usb_ep_resp u_resp (
        .clk       (clk),
        .rst_n     (rst_n),
        .tok_valid (tok_valid),
        .tok_dir   (tok_dir),
        .tok_pid   (tok_pid),
        .cfg_i     (cfg),
        .tgl_i     (tgl),
        .adv_o     (adv),
        .hs_valid  (hs_valid),
        .hs_code   (code),
        .hs_pid    (hs_pid)
    );

    assign hs_code = code;
    assign rx_tgl  = tgl[0];
    assign tx_tgl  = tgl[1];

endmodule

// File: tb/usb_ep_ctrl_tb.sv
module usb_ep_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic        setup_rcvd = 1'b0;
    logic        setup_stat = 1'b0;
    logic        tok_valid = 1'b0;
    logic        tok_dir = 1'b0;
    logic        tok_pid = 1'b0;
    logic        hs_valid;
    logic [1:0]  hs_code;
    logic        hs_pid;
    logic        rx_tgl;
    logic        tx_tgl;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    logic [2:0] exp_q[$];
    string      tag_q[$];

    always #2.5 clk = ~clk;

    usb_ep_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .setup_rcvd(setup_rcvd), .setup_stat(setup_stat), .tok_valid(tok_valid), .tok_dir(tok_dir),
        .tok_pid(tok_pid), .hs_valid(hs_valid), .hs_code(hs_code), .hs_pid(hs_pid),
        .rx_tgl(rx_tgl), .tx_tgl(tx_tgl)
    );

    task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] v);
        cfg_we = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic pulse_setup();
        setup_rcvd = 1'b1;
        @(negedge clk);
        setup_rcvd = 1'b0;
    endtask

    // Driver: present one token and push the expected {code, pid}.
    task automatic tok(input logic dir, input logic pid, input logic [1:0] code,
                       input logic epid, input string tag);
        tok_valid = 1'b1;
        tok_dir   = dir;
        tok_pid   = pid;
        exp_q.push_back({code, epid});
        tag_q.push_back(tag);
        @(negedge clk);
        tok_valid = 1'b0;
    endtask

    // Monitor: pop and compare every response, flag any unrequested one.
    always @(negedge clk) begin
        if (rst_n && hs_valid && !done) begin
            if (exp_q.size() == 0) begin
                total++;
                bad++;
                $display("FAIL R12: actual=response expected=none");
            end else begin
                logic [2:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk({13'd0, hs_code, hs_pid}, {13'd0, e}, t);
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk(cfg_rdata, 16'h0000, "R1 rdata");
        chk({15'd0, rx_tgl}, 16'd0, "R1 rx_tgl");
        chk({15'd0, tx_tgl}, 16'd0, "R1 tx_tgl");
        chk({15'd0, hs_valid}, 16'd0, "R1 hs_valid");

        // R3 disabled: silent, toggles untouched
        tok(1'b0, 1'b0, 2'd3, 1'b0, "R3 out disabled");
        tok(1'b1, 1'b0, 2'd3, 1'b0, "R3 in disabled");
        chk({14'd0, tx_tgl, rx_tgl}, 16'd0, "R3 toggles");

        // R2 configure both control, enabled
        wr(16'h0404);
        chk(cfg_rdata, 16'h0404, "R2 readback");

        // R7 OUT toggle sequence
        tok(1'b0, 1'b0, 2'd0, 1'b0, "R7 out data0 accept");
        chk({15'd0, rx_tgl}, 16'd1, "R7 rx flip");
        tok(1'b0, 1'b0, 2'd2, 1'b1, "R7 out mismatch drop");
        chk({15'd0, rx_tgl}, 16'd1, "R7 rx held");
        tok(1'b0, 1'b1, 2'd0, 1'b1, "R7 out data1 accept");
        chk({15'd0, rx_tgl}, 16'd0, "R7 rx flip back");

        // R8 IN sends alternating PIDs
        tok(1'b1, 1'b0, 2'd0, 1'b0, "R8 in data0");
        tok(1'b1, 1'b0, 2'd0, 1'b1, "R8 in data1");
        tok(1'b1, 1'b0, 2'd0, 1'b0, "R8 in data0 again");
        chk({15'd0, tx_tgl}, 16'd1, "R8 tx toggle");

        // R9 toggle reset
        tok(1'b0, 1'b0, 2'd0, 1'b0, "R9 prep accept");
        wr(16'h0414);
        chk(cfg_rdata, 16'h0404, "R9 rx reset reads 0");
        chk({15'd0, rx_tgl}, 16'd0, "R9 rx reset");
        wr(16'h1404);
        chk(cfg_rdata, 16'h0404, "R9 tx reset reads 0");
        chk({15'd0, tx_tgl}, 16'd0, "R9 tx reset");
        tok(1'b0, 1'b0, 2'd0, 1'b0, "R9 prep accept 2");
        wr(16'h0404);
        chk({15'd0, rx_tgl}, 16'd1, "R9 write 0 no effect");
        wr(16'h0414);
        chk({15'd0, rx_tgl}, 16'd0, "R9 rx reset again");

        // R4 stall on both directions, persistent
        wr(16'h0C0C);
        chk(cfg_rdata, 16'h0C0C, "R4 stall readback");
        tok(1'b0, 1'b0, 2'd1, 1'b0, "R4 out stall");
        tok(1'b1, 1'b0, 2'd1, 1'b0, "R4 in stall");
        tok(1'b0, 1'b0, 2'd1, 1'b0, "R4 out stall persists");
        chk({14'd0, tx_tgl, rx_tgl}, 16'd0, "R4 toggles held");

        // R5 setup clears and holds
        setup_stat = 1'b1;
        pulse_setup();
        chk(cfg_rdata, 16'h0404, "R5 setup clear");
        wr(16'h0C0C);
        chk(cfg_rdata, 16'h0404, "R5 held while status");
        setup_stat = 1'b0;
        wr(16'h0C0C);
        chk(cfg_rdata, 16'h0C0C, "R5 stall after status drop");
        cfg_we = 1'b1;
        cfg_wdata = 16'h0C0C;
        setup_rcvd = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
        setup_rcvd = 1'b0;
        chk(cfg_rdata, 16'h0404, "R5 setup beats write");

        // R6 bulk stall survives setup
        wr(16'h0E0E);
        pulse_setup();
        chk(cfg_rdata, 16'h0E0E, "R6 bulk stall kept");
        tok(1'b0, 1'b1, 2'd1, 1'b0, "R6 bulk stall answer");

        // R10 receive toggle inhibit
        wr(16'h0626);
        chk(cfg_rdata, 16'h0626, "R10 readback");
        tok(1'b0, 1'b1, 2'd0, 1'b0, "R10 data1 accepted");
        tok(1'b0, 1'b0, 2'd0, 1'b0, "R10 data0 accepted");
        chk({15'd0, rx_tgl}, 16'd0, "R10 rx held");

        // R11 isochronous: no check, no stall
        wr(16'h0D0D);
        tok(1'b0, 1'b1, 2'd0, 1'b0, "R11 iso out");
        tok(1'b1, 1'b0, 2'd0, 1'b0, "R11 iso in");
        chk({14'd0, tx_tgl, rx_tgl}, 16'd0, "R11 toggles held");

        // R3 disabled outranks stall
        wr(16'h000A);
        tok(1'b0, 1'b0, 2'd3, 1'b0, "R3 disabled stalled");

        repeat (3) @(negedge clk);
        chk(exp_q.size(), 16'd0, "R12 all responses seen");
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule